// File: doc/BRIEF.md
# Slave-SPI FPGA configuration sequencer

This block loads a configuration image into an SRAM-based FPGA through that device's SPI slave port. It owns the whole power-on sequence as the master. It pulses the target's active-low configuration reset with chip select held low. It then checks that the target's configuration-done line went low, and it waits out the target's internal housekeeping time. It shifts the image bytes out in SPI mode 0, most significant bit first. After the last byte it checks that configuration-done went high. If it did, the block sends the zero-valued activation clocks that start the loaded design.

A one-cycle `start_i` pulse begins a job. Image bytes arrive on a valid/ready byte stream, and `s_last_i` flags the final byte. The block keeps `busy_o` high for the whole job. It ends the job with a one-cycle `done_ok_o` or `error_o` pulse. All timings are derived from the clock frequency parameter. A divider parameter that would put SCK outside 1 MHz to 25 MHz stops elaboration.

Top module: `cfg_spi_loader`

## Requirements
- R1: After an accepted full start, `creset_n_o` and `cs_n_o` go low together. `creset_n_o` stays low for at least RESET_US microseconds (RST_CYC clock cycles). Whenever `creset_n_o` is low, `cs_n_o` is low too.
- R2: After reset is released, the synchronised done input is sampled with chip select still low. If it is high, the job ends with `error_o`, `s_ready_o` never rises and no SCK edge is produced.
- R3: `cs_n_o` stays low for at least HOUSEKEEP_US microseconds after `creset_n_o` rises, then goes high before any image byte is sent.
- R4: Bytes are sent in SPI mode 0 (SCK idles low, MOSI stable before each rising edge, changed only on falling edges), most significant bit first. SCK high and low phases each last HALF_DIV clock cycles.
- R5: A byte is taken only in a cycle where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high only while streaming, with the shifter idle and the last byte not yet taken. Every taken byte is sent exactly once.
- R6: After the byte flagged by `s_last_i` has been sent, the synchronised done input is sampled. If it is low, the job ends with `error_o` and no further SCK edges (exactly 8·N bits for N bytes).
- R7: If done is high, 7 zero bytes (56 SCK cycles with MOSI 0) follow, and the job ends with `done_ok_o`.
- R8: A start with `partial_i` high is refused. `error_o` is high in the cycle after the start, and `creset_n_o` never goes low.
- R9: `busy_o` is high from the cycle after start until the final pulse. `done_ok_o` and `error_o` are one-cycle pulses that are never high together. When idle, `creset_n_o`=1, `cs_n_o`=1, `sck_o`=0 and `busy_o`=0.
- R10: `start_i` is ignored while `busy_o` is high, even when `partial_i` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration job |
| partial_i | input | 1 | Request is a partial reconfiguration (refused) |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Image byte is the final one |
| s_ready_o | output | 1 | Block takes the image byte this cycle |
| cdone_i | input | 1 | Target configuration-done line (asynchronous) |
| creset_n_o | output | 1 | Target configuration reset, active low |
| cs_n_o | output | 1 | SPI chip select, active low |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to target |
| busy_o | output | 1 | Job in progress |
| done_ok_o | output | 1 | One-cycle pulse: configuration completed |
| error_o | output | 1 | One-cycle pulse: job failed or refused |

## Verification
The refusal of a partial request is due one cycle after the start. The bench reads `error_o` one nanosecond after that edge. Reset width and housekeeping time are counted in cycles at falling clock edges from the output transitions themselves, and compared against lower bounds: 101 and 505 cycles are produced, against 100 and 500 required. SPI data, the activation bits and the SCK phase lengths are captured by a target model at every SCK rise and fall. These are compared after `busy_o` drops, so no check depends on the exact cycle of a byte. The model raises the done line only once all N image bytes have arrived, which tests that the post-stream check waits for the shifter and the synchroniser.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST,
    ST_RCHK,
    ST_HK,
    ST_GAP,
    ST_STREAM,
    ST_DCHK,
    ST_ACT,
    ST_OK,
    ST_ERR
  } seq_state_t;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_countdown.sv
module cfg_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= value_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cfg_spi_byte_tx.sv
module cfg_spi_byte_tx #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       idle_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          active_q;
  logic          sck_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (!active_q) begin
      if (load_i) begin
        active_q <= 1'b1;
        sh_q     <= data_i;
        div_q    <= '0;
        bit_q    <= '0;
        sck_q    <= 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (!sck_q) begin
        sck_q <= 1'b1;
      end else begin
        sck_q <= 1'b0;
        sh_q  <= {sh_q[6:0], 1'b0};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) active_q <= 1'b0;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign idle_o = !active_q;
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];

  // R4
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sh_q[7]) |-> ($fell(sck_q) || $past(load_i)));
  // R4
  sck_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> active_q);
endmodule

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader
  import cfg_seq_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int HALF_DIV     = 4,
  parameter int RESET_US     = 1,
  parameter int HOUSEKEEP_US = 1200,
  parameter int CHK_CYC      = 3,
  parameter int ACT_BITS     = 49
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       cdone_i,
  output logic       creset_n_o,
  output logic       cs_n_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_ok_o,
  output logic       error_o
);
  localparam int    CLK_MHZ   = CLK_HZ / 1_000_000;
  localparam int    RST_CYC   = CLK_MHZ * RESET_US;
  localparam int    HK_CYC    = CLK_MHZ * HOUSEKEEP_US;
  localparam int    MAX_CYC   = (HK_CYC > RST_CYC) ? HK_CYC : RST_CYC;
  localparam int    CW        = $clog2(MAX_CYC + 1);
  localparam int    ACT_BYTES = (ACT_BITS + 7) / 8;
  localparam int    AW        = $clog2(ACT_BYTES + 1);
  localparam longint SCK_HZ   = longint'(CLK_HZ) / (2 * HALF_DIV);

  if (SCK_HZ > 64'd25_000_000 || SCK_HZ < 64'd1_000_000) begin : g_bad_sck
    $error("cfg_spi_loader: SCK frequency outside 1..25 MHz");
  end

  seq_state_t    st_q, st_d;
  logic          cdone_s;
  logic          t_zero, t_load;
  logic [CW-1:0] t_val;
  logic          tx_idle, tx_load;
  logic [7:0]    tx_data;
  logic          last_seen_q;
  logic [AW-1:0] act_cnt_q;
  logic          take;

  cfg_sync2 #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(cdone_i), .q_o(cdone_s));

  cfg_countdown #(.W(CW)) u_timer (
    .clk(clk), .rst(rst), .load_i(t_load), .value_i(t_val), .zero_o(t_zero));

  cfg_spi_byte_tx #(.HALF_DIV(HALF_DIV)) u_tx (
    .clk(clk), .rst(rst), .load_i(tx_load), .data_i(tx_data),
    .idle_o(tx_idle), .sck_o(sck_o), .mosi_o(mosi_o));

  assign s_ready_o = (st_q == ST_STREAM) && tx_idle && !last_seen_q;
  assign take      = s_valid_i && s_ready_o;
  assign tx_load   = take ||
                     ((st_q == ST_ACT) && tx_idle && (act_cnt_q != AW'(ACT_BYTES)));
  assign tx_data   = (st_q == ST_ACT) ? 8'h00 : s_data_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = partial_i ? ST_ERR : ST_RST;
      ST_RST:    if (t_zero) st_d = ST_RCHK;
      ST_RCHK:   if (t_zero) st_d = cdone_s ? ST_ERR : ST_HK;
      ST_HK:     if (t_zero) st_d = ST_GAP;
      ST_GAP:    st_d = ST_STREAM;
      ST_STREAM: if (tx_idle && last_seen_q) st_d = ST_DCHK;
      ST_DCHK:   if (t_zero) st_d = cdone_s ? ST_ACT : ST_ERR;
      ST_ACT:    if (tx_idle && act_cnt_q == AW'(ACT_BYTES)) st_d = ST_OK;
      ST_OK:     st_d = ST_IDLE;
      ST_ERR:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    t_load = (st_d != st_q);
    unique case (st_d)
      ST_RST:           t_val = CW'(RST_CYC);
      ST_HK:            t_val = CW'(HK_CYC);
      ST_RCHK, ST_DCHK: t_val = CW'(CHK_CYC);
      default:          t_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      last_seen_q <= 1'b0;
      act_cnt_q   <= '0;
      creset_n_o  <= 1'b1;
      cs_n_o      <= 1'b1;
      busy_o      <= 1'b0;
      done_ok_o   <= 1'b0;
      error_o     <= 1'b0;
    end else begin
      st_q       <= st_d;
      creset_n_o <= (st_d != ST_RST);
      cs_n_o     <= !(st_d inside {ST_RST, ST_RCHK, ST_HK, ST_STREAM, ST_DCHK, ST_ACT});
      busy_o     <= (st_d != ST_IDLE);
      done_ok_o  <= (st_d == ST_OK);
      error_o    <= (st_d == ST_ERR);
      if (st_q == ST_IDLE) begin
        last_seen_q <= 1'b0;
        act_cnt_q   <= '0;
      end else begin
        if (take && s_last_i) last_seen_q <= 1'b1;
        if (st_q == ST_ACT && tx_load) act_cnt_q <= act_cnt_q + 1'b1;
      end
    end
  end

  // R1
  cs_with_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !creset_n_o |-> !cs_n_o);
  // R9
  ok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_ok_o |=> !done_ok_o);
  // R9
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_ok_o && error_o));
  // R8
  partial_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && partial_i && !busy_o) |=> (error_o && creset_n_o));
  // R5
  one_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid_i && s_ready_o) |=> !s_ready_o);
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_ok_o && !error_o && start_i) |=> busy_o);
endmodule

// File: tb/test_cfg_spi_loader.sv
module test_cfg_spi_loader;
  localparam int HALF   = 2;
  localparam int HK_US  = 5;
  localparam int RSTMIN = 100;
  localparam int HKMIN  = 100 * HK_US;

  logic clk = 0, rst = 1;
  logic start = 0, partial = 0, s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, creset_n, cs_n, sck, mosi, busy, done_ok, error;
  logic cdone;

  int plan = 0;        // 0 good, 1 done stuck high, 2 done never rises
  int n_exp = 0;
  logic clr_req = 0;

  int rx_n, rst_low, cs_viol, hk_cnt, hk_meas, sck_bad, hi_run;
  int ok_cnt, err_cnt, acc_cnt, bits;
  bit hk_on, ready_seen, p_creset, p_cs, p_sck;
  logic [7:0] shreg;
  logic [7:0] rx [64];
  logic [7:0] txb [64];

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  cfg_spi_loader #(.CLK_HZ(100_000_000), .HALF_DIV(HALF), .RESET_US(1),
                   .HOUSEKEEP_US(HK_US), .CHK_CYC(3), .ACT_BITS(49)) i_cfg_spi_loader (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .cdone_i(cdone), .creset_n_o(creset_n), .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi),
    .busy_o(busy), .done_ok_o(done_ok), .error_o(error));

  assign cdone = (plan == 1) || (plan == 0 && rx_n >= n_exp);

  // target model and event counters
  always @(negedge clk) begin
    if (clr_req) begin
      rx_n = 0; rst_low = 0; cs_viol = 0; hk_cnt = 0; hk_meas = 0; hk_on = 0;
      sck_bad = 0; hi_run = 0; ok_cnt = 0; err_cnt = 0; acc_cnt = 0; bits = 0;
      ready_seen = 0; shreg = 0;
    end else begin
      if (!creset_n) rst_low++;
      if (!creset_n && cs_n) cs_viol++;
      if (!p_creset && creset_n) begin hk_on = 1; hk_cnt = 0; end
      if (hk_on) begin
        hk_cnt++;
        if (cs_n) begin hk_meas = hk_cnt; hk_on = 0; end
      end
      if (sck && !p_sck && !cs_n) begin
        shreg = {shreg[6:0], mosi};
        bits++;
        if (bits % 8 == 0 && rx_n < 64) begin rx[rx_n] = shreg; rx_n++; end
      end
      if (sck) hi_run++;
      if (!sck && p_sck) begin
        if (hi_run != HALF) sck_bad++;
        hi_run = 0;
      end
      if (done_ok) ok_cnt++;
      if (error) err_cnt++;
      if (s_ready) ready_seen = 1;
      if (s_ready && s_valid) acc_cnt++;
    end
    p_creset = creset_n; p_cs = cs_n; p_sck = sck;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic feed(int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(3) == 0) begin
        s_valid = 0;
        repeat ($urandom_range(1, 3)) step();
      end
      s_valid = 1; s_data = txb[i]; s_last = (i == n - 1);
      forever begin
        if (!busy) begin s_valid = 0; s_last = 0; return; end
        if (s_ready) begin step(); break; end
        step();
      end
    end
    s_valid = 0; s_last = 0;
  endtask

  task automatic run_job(int n, int pl, bit part, bit extra);
    int guard;
    plan = pl; n_exp = n;
    for (int i = 0; i < n; i++) txb[i] = 8'($urandom);
    clr_req = 1; step(); clr_req = 0;
    start = 1; partial = part; step();
    start = 0; partial = 0;
    if (part) chk(error == 1, "R8 error one cycle after partial start", int'(error), 1);
    else      chk(busy == 1, "R9 busy after start", int'(busy), 1);
    if (extra) begin
      repeat (50) step();
      start = 1; partial = 1; step(); start = 0; partial = 0;
    end
    feed(n);
    guard = 0;
    while (busy && guard < 20000) begin step(); guard++; end
    repeat (2) step();
    chk(!busy && creset_n && cs_n && !sck, "R9 idle levels after job",
        {busy, creset_n, cs_n, sck}, 4'b0110);
  endtask

  function automatic int data_mismatch(int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (rx[i] !== txb[i]) m++;
    return m;
  endfunction

  function automatic int tail_nonzero(int n);
    int m = 0;
    for (int i = n; i < n + 7; i++) if (rx[i] !== 8'h00) m++;
    return m;
  endfunction

  task automatic check_good(int n, string tag);
    chk(ok_cnt == 1, {tag, " R7 done_ok single pulse"}, ok_cnt, 1);
    chk(err_cnt == 0, {tag, " R9 no error"}, err_cnt, 0);
    chk(rst_low >= RSTMIN, {tag, " R1 reset width"}, rst_low, RSTMIN);
    chk(cs_viol == 0, {tag, " R1 cs low during reset"}, cs_viol, 0);
    chk(hk_meas >= HKMIN, {tag, " R3 housekeeping time"}, hk_meas, HKMIN);
    chk(acc_cnt == n, {tag, " R5 bytes taken"}, acc_cnt, n);
    chk(rx_n == n + 7, {tag, " R7 bytes on wire"}, rx_n, n + 7);
    chk(data_mismatch(n) == 0, {tag, " R4 data MSB first"}, data_mismatch(n), 0);
    chk(tail_nonzero(n) == 0, {tag, " R7 zero activation bytes"}, tail_nonzero(n), 0);
    chk(sck_bad == 0, {tag, " R4 sck phase length"}, sck_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) step();
    rst = 0; step();
    chk(creset_n == 1 && cs_n == 1 && sck == 0 && busy == 0 && !done_ok && !error,
        "R9 reset state", {creset_n, cs_n, sck, busy}, 4'b1100);

    run_job(1, 0, 0, 0);
    check_good(1, "single byte");
    for (int j = 0; j < 4; j++) begin
      int n = $urandom_range(2, 24);
      run_job(n, 0, 0, 0);
      check_good(n, "random stream");
    end

    run_job(5, 1, 0, 0);
    chk(err_cnt == 1, "R2 error when done stays high", err_cnt, 1);
    chk(ok_cnt == 0, "R2 no done_ok", ok_cnt, 0);
    chk(!ready_seen, "R2 s_ready never high", int'(ready_seen), 0);
    chk(rx_n == 0 && bits == 0, "R2 no SCK", bits, 0);
    chk(rst_low >= RSTMIN, "R1 reset width before failed check", rst_low, RSTMIN);

    run_job(3, 2, 0, 0);
    chk(err_cnt == 1, "R6 error when done stays low", err_cnt, 1);
    chk(ok_cnt == 0, "R6 no done_ok", ok_cnt, 0);
    chk(bits == 24, "R6 no activation clocks", bits, 24);
    chk(data_mismatch(3) == 0, "R4 data before failed check", data_mismatch(3), 0);

    run_job(4, 0, 1, 0);
    chk(rst_low == 0, "R8 reset never driven", rst_low, 0);
    chk(err_cnt == 1, "R8 single error pulse", err_cnt, 1);
    chk(bits == 0, "R8 no SCK", bits, 0);

    run_job(6, 0, 0, 1);
    check_good(6, "R10 start while busy");

    finish_run();
  end
endmodule